// File: doc/BRIEF.md
# Indexed Block Register Target for a Two-Wire Serial Bus

This block is a target on a two-wire serial bus (I2C) that holds a bank of byte-wide configuration registers for clock-control logic. Both bus lines are oversampled by the system clock. The block pulls the data line low to acknowledge and to send zeros, and it never drives the clock line. Every transfer names a start index. Writes also carry a byte count that limits how many data bytes are taken. A read returns the value of a writable count register first and then the register contents from the start index onward.

The whole register image is presented in parallel to the clock-control logic. Two strap fields are captured while reset is held: a five-bit frequency select and a two-bit drive-multiplier select. They appear as read-only bits inside the register image. A frequency-select output follows the captured strap unless two conditions both hold: a global program-enable bit is set, and a use-programmed bit is set. In that case it follows a programmed field.

Top module: `i2cx_target`

## Requirements
- R1: The target acknowledges the address byte D2h (write) and D3h (read). Any other address byte is not acknowledged, and the data line stays released until the next start or stop.
- R2: A write is D2h, then the index byte N, then the count byte X, then data bytes. Each of these bytes is acknowledged (data line low during the ninth clock), and the data lands in registers N, N+1, and so on.
- R3: Once X data bytes have been taken, a further data byte is not acknowledged and is not stored. A count of 0 refuses the first data byte.
- R4: A read is D2h and index N, then a repeated start and D3h. The target then sends the count register first, followed by registers N, N+1, and so on, most significant bit first.
- R5: The count register sits at index 8 and resets to 0Fh. A write changes the value that later reads send first.
- R6: Register 1 bits [4:0] read as the frequency strap and register 4 bits [7:6] read as the multiplier strap, both captured during reset. Bus writes to these bits are ignored, and the other bits of those registers stay writable.
- R7: `fsel_eff` equals register 0 bits [4:0] when register 10 bit 7 (program enable, also on `prog_enable`) and register 0 bit 7 (use programmed) are both 1. Otherwise it equals the captured frequency strap.
- R8: A stop at any point, including inside a byte, releases the data line and returns the target to idle. Bus clocks after that are ignored until a new start, and a byte cut off by the stop writes nothing.
- R9: After the host does not acknowledge a read byte, the target releases the data line and sends nothing more until the next start.
- R10: After reset, the data line is released, every register is 00h except the count register (0Fh) and the strap bits, and `fsel_eff` equals the frequency strap.
- R11: With the default 24 registers, indices 24 and above are accepted on the bus and acknowledged. Writes to them are dropped, and reads from them return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset; straps are captured while it is high |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull_low | output | 1 | 1 pulls the data line low (open-drain drive) |
| strap_fsel | input | 5 | Frequency-select strap pins |
| strap_mult | input | 2 | Drive-multiplier strap pins |
| cfg_image | output | NUM_REGS*8 | All registers as read, register i at bits [8i+7:8i] |
| prog_enable | output | 1 | Global program-enable bit |
| fsel_eff | output | 5 | Frequency select in effect |

## Verification
The properties rely on the host changing the data line only while the clock line is low, except to make starts and stops. They also rely on each clock-line level lasting well beyond the synchronizer delay, so every drive change of the target traces back to a detected falling clock edge, a start or a stop. The straps are assumed constant once reset is released. The bench drives these conditions on purpose: each bus bit holds every level for ten system clocks or more, it changes the data line only at the middle of the low phase, and it sets the straps once before reset.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;

   localparam int BYTE_W = 8;
   localparam int FSEL_W = 5;
   localparam int MULT_W = 2;

   typedef logic [BYTE_W-1:0] byte_t;

   typedef enum logic [2:0] {
      LS_IDLE,
      LS_RX,
      LS_RX_ACK,
      LS_TX,
      LS_TX_ACK,
      LS_WAIT
   } link_st_e;

   typedef enum logic [1:0] {
      RB_ADDR,
      RB_INDEX,
      RB_COUNT,
      RB_DATA
   } rx_role_e;

endpackage

// File: rtl/i2cx_line_sync.sv
module i2cx_line_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_seen,
   output logic stop_seen
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("i2cx_line_sync: SYNC_STAGES must be at least 2");
   end

   localparam int LINES = 2;

   logic [LINES-1:0] raw;
   logic [LINES-1:0] synced;
   logic [LINES-1:0] synced_d;

   assign raw = {sda_in, scl_in};

   for (genvar l = 0; l < LINES; l++) begin : g_line
      logic [SYNC_STAGES-1:0] pipe;
      always_ff @(posedge clk) begin
         if (rst) pipe <= '1;
         else     pipe <= {pipe[SYNC_STAGES-2:0], raw[l]};
      end
      assign synced[l] = pipe[SYNC_STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (rst) synced_d <= '1;
      else     synced_d <= synced;
   end

   logic scl_now, scl_was, sda_now, sda_was;
   assign scl_now = synced[0];
   assign scl_was = synced_d[0];
   assign sda_now = synced[1];
   assign sda_was = synced_d[1];

   assign sda_q      = sda_now;
   assign scl_rise   = scl_now & ~scl_was;
   assign scl_fall   = ~scl_now & scl_was;
   assign start_seen = scl_now & scl_was & sda_was & ~sda_now;
   assign stop_seen  = scl_now & scl_was & ~sda_was & sda_now;

endmodule

// File: rtl/i2cx_regbank.sv
module i2cx_regbank
   import i2cx_pkg::*;
#(
   parameter int    NUM_REGS = 24,
   parameter int    CNT_IDX  = 8,
   parameter byte_t CNT_RST  = 8'h0F,
   parameter int    FSEL_IDX = 1,
   parameter int    FSEL_LSB = 0,
   parameter int    MULT_IDX = 4,
   parameter int    MULT_LSB = 6,
   parameter int    PEN_IDX  = 10,
   parameter int    PEN_BIT  = 7,
   parameter int    SEL_IDX  = 0,
   parameter int    SEL_BIT  = 7
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [FSEL_W-1:0]     strap_fsel,
   input  logic [MULT_W-1:0]     strap_mult,
   input  logic                  wr_en,
   input  byte_t                 wr_idx,
   input  byte_t                 wr_data,
   input  byte_t                 rd_idx,
   output byte_t                 rd_data,
   output byte_t                 count_val,
   output logic [NUM_REGS*8-1:0] image,
   output logic                  prog_en,
   output logic [FSEL_W-1:0]     fsel_eff
);

   localparam int RIDX_W = (NUM_REGS > 2) ? $clog2(NUM_REGS) : 1;
   localparam logic [BYTE_W:0] NREG_C = (BYTE_W+1)'(NUM_REGS);

   if (NUM_REGS < 2 || NUM_REGS > 256) begin : g_bad_num
      $error("i2cx_regbank: NUM_REGS out of range 2..256");
   end
   if (CNT_IDX >= NUM_REGS || FSEL_IDX >= NUM_REGS || MULT_IDX >= NUM_REGS ||
       PEN_IDX >= NUM_REGS || SEL_IDX >= NUM_REGS) begin : g_bad_idx
      $error("i2cx_regbank: a special register index lies outside the bank");
   end
   if (FSEL_LSB + FSEL_W > BYTE_W || MULT_LSB + MULT_W > BYTE_W) begin : g_bad_lsb
      $error("i2cx_regbank: a strap field does not fit in a byte");
   end
   if (SEL_BIT < FSEL_W || PEN_BIT >= BYTE_W || SEL_BIT >= BYTE_W) begin : g_bad_bit
      $error("i2cx_regbank: control bit positions overlap the programmed field");
   end
   if (CNT_IDX == FSEL_IDX || CNT_IDX == MULT_IDX || SEL_IDX == FSEL_IDX ||
       SEL_IDX == MULT_IDX || PEN_IDX == FSEL_IDX || PEN_IDX == MULT_IDX) begin : g_bad_share
      $error("i2cx_regbank: writable control registers may not hold strap bits");
   end

   function automatic byte_t ro_mask_f(input int r);
      byte_t m;
      m = '0;
      if (r == FSEL_IDX) m = m | (byte_t'({FSEL_W{1'b1}}) << FSEL_LSB);
      if (r == MULT_IDX) m = m | (byte_t'({MULT_W{1'b1}}) << MULT_LSB);
      return m;
   endfunction

   logic [FSEL_W-1:0] fsel_cap;
   logic [MULT_W-1:0] mult_cap;

   always_ff @(posedge clk) begin
      if (rst) begin
         fsel_cap <= strap_fsel;
         mult_cap <= strap_mult;
      end
   end

   byte_t ovl_fsel, ovl_mult;
   assign ovl_fsel = byte_t'(fsel_cap) << FSEL_LSB;
   assign ovl_mult = byte_t'(mult_cap) << MULT_LSB;

   byte_t view [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam byte_t RO_M  = ro_mask_f(i);
      localparam byte_t RST_V = (i == CNT_IDX) ? CNT_RST : '0;
      localparam byte_t MY_IX = byte_t'(i);
      byte_t stor;
      byte_t ovl;

      always_ff @(posedge clk) begin
         if (rst)                              stor <= RST_V & ~RO_M;
         else if (wr_en && (wr_idx == MY_IX))  stor <= wr_data & ~RO_M;
      end

      assign ovl = ((i == FSEL_IDX) ? ovl_fsel : '0) |
                   ((i == MULT_IDX) ? ovl_mult : '0);
      assign view[i] = (stor & ~RO_M) | (ovl & RO_M);
      assign image[i*8 +: 8] = view[i];
   end

   assign rd_data   = ({1'b0, rd_idx} < NREG_C) ? view[rd_idx[RIDX_W-1:0]] : '0;
   assign count_val = view[CNT_IDX];

   logic use_prog;
   assign prog_en  = view[PEN_IDX][PEN_BIT];
   assign use_prog = view[SEL_IDX][SEL_BIT];
   assign fsel_eff = (prog_en && use_prog) ? view[SEL_IDX][FSEL_W-1:0] : fsel_cap;

endmodule

// File: rtl/i2cx_link.sv
module i2cx_link
   import i2cx_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h69
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  sda_q,
   input  logic  scl_rise,
   input  logic  scl_fall,
   input  logic  start_seen,
   input  logic  stop_seen,
   input  byte_t rd_data,
   input  byte_t count_val,
   output byte_t rd_idx,
   output logic  wr_en,
   output byte_t wr_idx,
   output byte_t wr_data,
   output logic  sda_low
);

   link_st_e state;
   rx_role_e role;
   logic [2:0] bit_n;
   logic       got8;
   logic       to_tx;
   logic       host_ack;
   byte_t      shreg;
   byte_t      tx_sh;
   byte_t      idx;
   byte_t      remain;

   assign rd_idx = idx;

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= LS_IDLE;
         role     <= RB_ADDR;
         bit_n    <= '0;
         got8     <= 1'b0;
         to_tx    <= 1'b0;
         host_ack <= 1'b0;
         shreg    <= '0;
         tx_sh    <= '0;
         idx      <= '0;
         remain   <= '0;
         sda_low  <= 1'b0;
         wr_en    <= 1'b0;
         wr_idx   <= '0;
         wr_data  <= '0;
      end else begin
         wr_en <= 1'b0;
         if (stop_seen) begin
            state   <= LS_IDLE;
            got8    <= 1'b0;
            sda_low <= 1'b0;
         end else if (start_seen) begin
            state   <= LS_RX;
            role    <= RB_ADDR;
            bit_n   <= '0;
            got8    <= 1'b0;
            sda_low <= 1'b0;
         end else begin
            case (state)
               LS_RX: begin
                  if (scl_rise) begin
                     shreg <= {shreg[6:0], sda_q};
                     bit_n <= bit_n + 3'd1;
                     if (bit_n == 3'd7) got8 <= 1'b1;
                  end else if (scl_fall && got8) begin
                     got8  <= 1'b0;
                     to_tx <= 1'b0;
                     case (role)
                        RB_ADDR: begin
                           if (shreg[7:1] == DEV_ADDR) begin
                              state   <= LS_RX_ACK;
                              sda_low <= 1'b1;
                              to_tx   <= shreg[0];
                              role    <= RB_INDEX;
                           end else begin
                              state <= LS_WAIT;
                           end
                        end
                        RB_INDEX: begin
                           idx     <= shreg;
                           role    <= RB_COUNT;
                           state   <= LS_RX_ACK;
                           sda_low <= 1'b1;
                        end
                        RB_COUNT: begin
                           remain  <= shreg;
                           role    <= RB_DATA;
                           state   <= LS_RX_ACK;
                           sda_low <= 1'b1;
                        end
                        default: begin
                           if (remain != '0) begin
                              wr_en   <= 1'b1;
                              wr_idx  <= idx;
                              wr_data <= shreg;
                              idx     <= idx + 8'd1;
                              remain  <= remain - 8'd1;
                              state   <= LS_RX_ACK;
                              sda_low <= 1'b1;
                           end else begin
                              state <= LS_WAIT;
                           end
                        end
                     endcase
                  end
               end
               LS_RX_ACK: begin
                  if (scl_fall) begin
                     bit_n <= '0;
                     if (to_tx) begin
                        state   <= LS_TX;
                        tx_sh   <= count_val;
                        sda_low <= ~count_val[7];
                     end else begin
                        state   <= LS_RX;
                        sda_low <= 1'b0;
                     end
                  end
               end
               LS_TX: begin
                  if (scl_fall) begin
                     if (bit_n == 3'd7) begin
                        sda_low <= 1'b0;
                        state   <= LS_TX_ACK;
                     end else begin
                        tx_sh   <= {tx_sh[6:0], 1'b0};
                        sda_low <= ~tx_sh[6];
                        bit_n   <= bit_n + 3'd1;
                     end
                  end
               end
               LS_TX_ACK: begin
                  if (scl_rise) begin
                     host_ack <= ~sda_q;
                  end else if (scl_fall) begin
                     if (host_ack) begin
                        tx_sh   <= rd_data;
                        sda_low <= ~rd_data[7];
                        idx     <= idx + 8'd1;
                        bit_n   <= '0;
                        state   <= LS_TX;
                     end else begin
                        state <= LS_WAIT;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/i2cx_target.sv
module i2cx_target
   import i2cx_pkg::*;
#(
   parameter int         NUM_REGS    = 24,
   parameter logic [6:0] DEV_ADDR    = 7'h69,
   parameter int         SYNC_STAGES = 2,
   parameter int         CNT_IDX     = 8,
   parameter byte_t      CNT_RST     = 8'h0F,
   parameter int         FSEL_IDX    = 1,
   parameter int         FSEL_LSB    = 0,
   parameter int         MULT_IDX    = 4,
   parameter int         MULT_LSB    = 6,
   parameter int         PEN_IDX     = 10,
   parameter int         PEN_BIT     = 7,
   parameter int         SEL_IDX     = 0,
   parameter int         SEL_BIT     = 7
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  scl_in,
   input  logic                  sda_in,
   output logic                  sda_pull_low,
   input  logic [4:0]            strap_fsel,
   input  logic [1:0]            strap_mult,
   output logic [NUM_REGS*8-1:0] cfg_image,
   output logic                  prog_enable,
   output logic [4:0]            fsel_eff
);

   logic  sda_q, ev_rise, ev_fall, ev_start, ev_stop;
   logic  wr_en;
   byte_t wr_idx, wr_data, rd_idx, rd_data, count_val;

   i2cx_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst        (rst),
      .scl_in     (scl_in),
      .sda_in     (sda_in),
      .sda_q      (sda_q),
      .scl_rise   (ev_rise),
      .scl_fall   (ev_fall),
      .start_seen (ev_start),
      .stop_seen  (ev_stop)
   );

   i2cx_link #(.DEV_ADDR(DEV_ADDR)) u_link (
      .clk        (clk),
      .rst        (rst),
      .sda_q      (sda_q),
      .scl_rise   (ev_rise),
      .scl_fall   (ev_fall),
      .start_seen (ev_start),
      .stop_seen  (ev_stop),
      .rd_data    (rd_data),
      .count_val  (count_val),
      .rd_idx     (rd_idx),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data),
      .sda_low    (sda_pull_low)
   );

   i2cx_regbank #(
      .NUM_REGS (NUM_REGS),
      .CNT_IDX  (CNT_IDX),
      .CNT_RST  (CNT_RST),
      .FSEL_IDX (FSEL_IDX),
      .FSEL_LSB (FSEL_LSB),
      .MULT_IDX (MULT_IDX),
      .MULT_LSB (MULT_LSB),
      .PEN_IDX  (PEN_IDX),
      .PEN_BIT  (PEN_BIT),
      .SEL_IDX  (SEL_IDX),
      .SEL_BIT  (SEL_BIT)
   ) u_bank (
      .clk        (clk),
      .rst        (rst),
      .strap_fsel (strap_fsel),
      .strap_mult (strap_mult),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data),
      .rd_idx     (rd_idx),
      .rd_data    (rd_data),
      .count_val  (count_val),
      .image      (cfg_image),
      .prog_en    (prog_enable),
      .fsel_eff   (fsel_eff)
   );

endmodule

// File: rtl/i2cx_target_chk.sv
module i2cx_target_chk #(
   parameter int         NUM_REGS = 24,
   parameter int         CNT_IDX  = 8,
   parameter logic [7:0] CNT_RST  = 8'h0F,
   parameter int         FSEL_IDX = 1,
   parameter int         FSEL_LSB = 0
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  scl_fall,
   input logic                  start_seen,
   input logic                  stop_seen,
   input logic                  sda_pull_low,
   input logic [NUM_REGS*8-1:0] cfg_image,
   input logic                  prog_enable,
   input logic [4:0]            fsel_eff
);

   logic [4:0] fsel_view;
   assign fsel_view = cfg_image[FSEL_IDX*8+FSEL_LSB +: 5];

   // R8: a stop always frees the data line on the next cycle
   p_stop_release_r8: assert property (@(posedge clk) disable iff (rst)
      stop_seen |=> !sda_pull_low);

   // R1: a start always frees the data line before the address byte
   p_start_release_r1: assert property (@(posedge clk) disable iff (rst)
      start_seen |=> !sda_pull_low);

   // R2: the drive only moves after a falling clock edge, a start or a stop
   p_drive_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
      !$stable(sda_pull_low) |-> $past(scl_fall || start_seen || stop_seen));

   // R10: leaving reset, the count register holds its reset value and the line is free
   p_count_reset_r10: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (cfg_image[CNT_IDX*8 +: 8] == CNT_RST) && !sda_pull_low);

   // R6: the reflected strap field never moves outside reset
   p_strap_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> $stable(fsel_view));

   // R7: without program enable the selection follows the strap reflection
   p_fsel_strap_r7: assert property (@(posedge clk) disable iff (rst)
      !prog_enable |-> (fsel_eff == fsel_view));

endmodule

bind i2cx_target i2cx_target_chk #(
   .NUM_REGS (NUM_REGS),
   .CNT_IDX  (CNT_IDX),
   .CNT_RST  (CNT_RST),
   .FSEL_IDX (FSEL_IDX),
   .FSEL_LSB (FSEL_LSB)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .scl_fall     (ev_fall),
   .start_seen   (ev_start),
   .stop_seen    (ev_stop),
   .sda_pull_low (sda_pull_low),
   .cfg_image    (cfg_image),
   .prog_enable  (prog_enable),
   .fsel_eff     (fsel_eff)
);

// File: tb/i2cx_target_tb_top.sv
`timescale 1ns/1ps
module i2cx_target_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NREG       = 24;
   localparam int Q          = 10;
   localparam int WDOG       = 150000;
   localparam logic [4:0] FSTRAP = 5'h15;
   localparam logic [1:0] MSTRAP = 2'b10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic scl_h = 1'b1;
   logic sda_h_low = 1'b0;
   logic sda_pull_low;
   logic sda_line;
   logic [NREG*8-1:0] cfg_image;
   logic prog_enable;
   logic [4:0] fsel_eff;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_line = ~(sda_h_low | sda_pull_low);

   i2cx_target dut_i (
      .clk          (clk),
      .rst          (rst),
      .scl_in       (scl_h),
      .sda_in       (sda_line),
      .sda_pull_low (sda_pull_low),
      .strap_fsel   (FSTRAP),
      .strap_mult   (MSTRAP),
      .cfg_image    (cfg_image),
      .prog_enable  (prog_enable),
      .fsel_eff     (fsel_eff)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] img(input int i);
      return cfg_image[i*8 +: 8];
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_h_low = 1'b1; tick(Q);
      scl_h = 1'b0;     tick(Q);
   endtask

   task automatic bus_rstart();
      sda_h_low = 1'b0; tick(Q);
      scl_h = 1'b1;     tick(Q);
      sda_h_low = 1'b1; tick(Q);
      scl_h = 1'b0;     tick(Q);
   endtask

   task automatic bus_stop();
      sda_h_low = 1'b1; tick(Q);
      scl_h = 1'b1;     tick(Q);
      sda_h_low = 1'b0; tick(Q);
   endtask

   task automatic send_bit(input logic b);
      sda_h_low = ~b; tick(Q);
      scl_h = 1'b1;   tick(2*Q);
      scl_h = 1'b0;   tick(Q);
   endtask

   task automatic recv_bit(output logic b);
      sda_h_low = 1'b0; tick(Q);
      scl_h = 1'b1;     tick(Q);
      b = sda_line;     tick(Q);
      scl_h = 1'b0;     tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      recv_bit(b);
      ack = ~b;
   endtask

   task automatic recv_byte(output logic [7:0] d, input logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         d[i] = b;
      end
      send_bit(~ack);
   endtask

   // full indexed write; returns header acks and per-byte data acks
   task automatic xfer_write(input logic [7:0] idx, input logic [7:0] cnt, input int n,
                             input logic [7:0] d [4], output logic [2:0] hdr, output logic [3:0] dak);
      logic a;
      dak = '0;
      bus_start();
      send_byte(8'hD2, a); hdr[0] = a;
      send_byte(idx, a);   hdr[1] = a;
      send_byte(cnt, a);   hdr[2] = a;
      for (int i = 0; i < n; i++) begin
         send_byte(d[i], a);
         dak[i] = a;
      end
      bus_stop();
   endtask

   task automatic write1(input logic [7:0] idx, input logic [7:0] v);
      logic [7:0] d [4];
      logic [2:0] h;
      logic [3:0] k;
      d = '{v, 8'h00, 8'h00, 8'h00};
      xfer_write(idx, 8'd1, 1, d, h, k);
   endtask

   // indexed read of count plus n data bytes, host NACKs the last
   task automatic xfer_read(input logic [7:0] idx, input int n, output logic [7:0] cntb,
                            output logic [7:0] d [4], output logic [2:0] hdr, input bit extra,
                            output logic [7:0] extra_b);
      logic a;
      bus_start();
      send_byte(8'hD2, a); hdr[0] = a;
      send_byte(idx, a);   hdr[1] = a;
      bus_rstart();
      send_byte(8'hD3, a); hdr[2] = a;
      recv_byte(cntb, 1'b1);
      for (int i = 0; i < n; i++) recv_byte(d[i], i < n-1);
      extra_b = 8'hFF;
      if (extra) recv_byte(extra_b, 1'b0);
      bus_stop();
   endtask

   task automatic t_reset();
      chk("R10", "line released", sda_pull_low, 1'b0);
      chk("R10", "fsel_eff strap", fsel_eff, FSTRAP);
      chk("R10", "count reg", img(8), 8'h0F);
      chk("R10", "reg0", img(0), 8'h00);
      chk("R10", "prog_enable", prog_enable, 1'b0);
      chk("R6", "fsel reflect", img(1), 8'h15);
      chk("R6", "mult reflect", img(4), 8'h80);
   endtask

   task automatic t_address();
      logic a;
      bus_start();
      send_byte(8'hA4, a);
      chk("R1", "foreign addr nack", a, 1'b0);
      send_byte(8'h00, a);
      chk("R1", "no ack after foreign addr", a, 1'b0);
      bus_stop();
      chk("R1", "line released", sda_pull_low, 1'b0);
      bus_start();
      send_byte(8'hD2, a);
      chk("R1", "D2 ack", a, 1'b1);
      bus_stop();
   endtask

   task automatic t_block_write();
      logic [7:0] d [4];
      logic [2:0] h;
      logic [3:0] k;
      d = '{8'hA1, 8'hB2, 8'hC3, 8'h00};
      xfer_write(8'h0B, 8'd3, 3, d, h, k);
      chk("R2", "header acks", h, 3'b111);
      chk("R2", "data acks", k, 4'b0111);
      chk("R2", "reg11", img(11), 8'hA1);
      chk("R2", "reg12", img(12), 8'hB2);
      chk("R2", "reg13", img(13), 8'hC3);
   endtask

   task automatic t_past_count();
      logic [7:0] d [4];
      logic [2:0] h;
      logic [3:0] k;
      d = '{8'h5A, 8'h6B, 8'h00, 8'h00};
      xfer_write(8'h0E, 8'd1, 2, d, h, k);
      chk("R3", "acks past count", k, 4'b0001);
      chk("R3", "reg14 written", img(14), 8'h5A);
      chk("R3", "reg15 untouched", img(15), 8'h00);
      d = '{8'h77, 8'h00, 8'h00, 8'h00};
      xfer_write(8'h10, 8'd0, 1, d, h, k);
      chk("R3", "zero count nack", k, 4'b0000);
      chk("R3", "reg16 untouched", img(16), 8'h00);
   endtask

   task automatic t_read();
      logic [7:0] c, x;
      logic [7:0] d [4];
      logic [2:0] h;
      xfer_read(8'h0B, 3, c, d, h, 1'b1, x);
      chk("R4", "read header acks", h, 3'b111);
      chk("R4", "count first", c, 8'h0F);
      chk("R4", "data N", d[0], 8'hA1);
      chk("R4", "data N+1", d[1], 8'hB2);
      chk("R4", "data N+2", d[2], 8'hC3);
      chk("R9", "silent after host nack", x, 8'hFF);
   endtask

   task automatic t_count_reg();
      logic [7:0] c, x;
      logic [7:0] d [4];
      logic [2:0] h;
      write1(8'd8, 8'h02);
      chk("R5", "count reg image", img(8), 8'h02);
      xfer_read(8'h0C, 2, c, d, h, 1'b0, x);
      chk("R5", "new count first", c, 8'h02);
      chk("R5", "data after count", d[0], 8'hB2);
   endtask

   task automatic t_readonly();
      logic [7:0] c, x;
      logic [7:0] d [4];
      logic [2:0] h;
      write1(8'd1, 8'hE0);
      chk("R6", "reg1 strap kept", img(1), 8'hF5);
      write1(8'd4, 8'h00);
      chk("R6", "reg4 strap kept", img(4), 8'h80);
      write1(8'd4, 8'h3F);
      chk("R6", "reg4 low bits writable", img(4), 8'hBF);
      xfer_read(8'h01, 1, c, d, h, 1'b0, x);
      chk("R6", "reg1 bus read", d[0], 8'hF5);
   endtask

   task automatic t_fsel();
      write1(8'd0, 8'h83);
      chk("R7", "no program enable", fsel_eff, FSTRAP);
      write1(8'd10, 8'h80);
      chk("R7", "prog_enable out", prog_enable, 1'b1);
      chk("R7", "programmed select", fsel_eff, 5'h03);
      write1(8'd0, 8'h03);
      chk("R7", "use bit cleared", fsel_eff, FSTRAP);
   endtask

   task automatic t_stop_mid();
      logic a;
      bus_start();
      send_byte(8'hD2, a);
      send_byte(8'h14, a);
      send_byte(8'h02, a);
      send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
      bus_stop();
      chk("R8", "released after stop", sda_pull_low, 1'b0);
      chk("R8", "cut byte not written", img(20), 8'h00);
      scl_h = 1'b0; tick(Q);
      send_byte(8'hD2, a);
      chk("R8", "idle ignores clocks", a, 1'b0);
      bus_stop();
      chk("R8", "still unwritten", img(20), 8'h00);
      write1(8'h14, 8'h3C);
      chk("R8", "recovers on next start", img(20), 8'h3C);
   endtask

   task automatic t_range();
      logic [7:0] c, x;
      logic [7:0] d [4];
      logic [2:0] h;
      logic [3:0] k;
      d = '{8'h11, 8'h22, 8'h00, 8'h00};
      xfer_write(8'h17, 8'd2, 2, d, h, k);
      chk("R11", "acks at edge", k, 4'b0011);
      chk("R11", "last reg written", img(23), 8'h11);
      xfer_read(8'h17, 2, c, d, h, 1'b0, x);
      chk("R11", "last reg read", d[0], 8'h11);
      chk("R11", "beyond bank reads 0", d[1], 8'h00);
   endtask

   initial begin
      tick(8);
      rst = 1'b0;
      tick(8);
      t_reset();
      t_address();
      t_block_write();
      t_past_count();
      t_read();
      t_count_reg();
      t_readonly();
      t_fsel();
      t_stop_mid();
      t_range();
      tick(20);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (WDOG) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual expired expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule